// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one outgoing packet onto a low-speed USB differential pair. A transmission is started either by a data request, which carries a total byte count, or by a handshake request. The block sends the sync byte itself. For a data packet it then pulls the remaining bytes one at a time from a byte source through a fetch strobe. For a handshake it sends a single PID byte, ACK or NAK, that it holds internally. Every line symbol lasts a fixed number of clocks, ten by default.

The bits go out least significant bit first and are NRZI encoded. A stuffed toggle is added after every run of six ones, and the run count does not restart at a byte boundary. Before the first bit the pair sits at J, first with the drivers off and then with them on. After the last bit, including any trailing stuffed toggle, the block drives two symbols of SE0, then one symbol of J, and then turns the drivers off.

A pending device address is copied into the active address register when the end-of-packet of a data packet begins. A handshake leaves the active address unchanged. Busy covers the whole sequence, and a one-clock done pulse marks the release of the bus.

Top module: `lsUsbTx`

## Requirements
- R1: After reset, busy, done, lineOe and fetchReq are 0, devAddr is 0, and the lines rest at J (dPlus=0, dMinus=1).
- R2: A start is accepted only while idle and only with byteCount from 2 to 12 inclusive. A start outside that range has no effect, and any start or handshake request made while busy has no effect.
- R3: The accept edge begins one symbol of J with lineOe=0. One symbol of J with lineOe=1 follows, and then the first data symbol.
- R4: A data packet sends the sync byte 0x80, then byteCount-1 bytes taken from fetchData in fetch order. fetchReq is high for one clock per byte, and fetchData is sampled on that edge, which is the edge that places the previous byte's last bit.
- R5: Bits go out LSB first in NRZI. A 0 bit toggles the pair and a 1 bit holds it. J is dPlus=0, dMinus=1 and K is the opposite.
- R6: After six consecutive 1 bits a stuffed toggle is inserted. The run count carries across byte boundaries and also applies after the last byte.
- R7: Every line symbol stays constant for exactly BIT_CLKS (10) clocks.
- R8: After the last symbol the block drives two symbols of SE0 (dPlus=dMinus=0), then one symbol of J, and then sets lineOe to 0.
- R9: busy is high from the accept edge to the release edge. done is a one-clock pulse on the release edge.
- R10: hsAck sends sync followed by 0xD2, and hsNak sends sync followed by 0x5A, with no fetches. hsAck wins over hsNak, and either one wins over start.
- R11: At the start of SE0 of a data packet, devAddr takes newAddr. A handshake leaves devAddr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a data packet |
| byteCount | input | 4 | Total bytes including sync (2..12) |
| fetchReq | output | 1 | Byte fetch strobe to the source |
| fetchData | input | 8 | Byte from the source, valid while fetchReq is high |
| hsAck | input | 1 | Request to send an ACK handshake |
| hsNak | input | 1 | Request to send a NAK handshake |
| newAddr | input | 7 | Pending device address |
| devAddr | output | 7 | Active device address |
| dPlus | output | 1 | D+ line level |
| dMinus | output | 1 | D- line level |
| lineOe | output | 1 | Line driver enable |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-clock pulse on bus release |

## Verification
The bench targets the following corner cases. Each one is listed with how a design that got it wrong would show up.

- **All-ones payload.** A run of ones starts at the tail of the sync byte and crosses into the next byte. A transmitter that cleared its run count at each byte would place the stuffed toggle late or leave it out.
- **Trailing stuffed bit.** A final byte ending in six ones needs a stuffed toggle before SE0. Omitting it would start SE0 one symbol early.
- **Request priority and requests while busy.** Handshake requests are raised together with each other and with start, and start and hsNak are also raised while a packet is already going out. A wrong priority would send the wrong PID or fetch bytes, and a missed busy guard would corrupt the packet or send a second one.
- **Address commit.** After a handshake the bench checks that devAddr did not move, which catches a commit that ignores the packet type.

// File: rtl/lsUsbTxPkg.sv
package lsUsbTxPkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h80;
  localparam logic [BYTE_W-1:0] PID_ACK = 8'hD2;
  localparam logic [BYTE_W-1:0] PID_NAK = 8'h5A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LEAD, ST_SEND, ST_EOP, ST_TAIL
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSync;
    logic emit;
    logic loadNext;
    logic useFetch;
    logic driveSe0;
    logic driveJ;
    logic oeOn;
    logic oeOff;
    logic commit;
  } txStrobes_t;
endpackage

// File: rtl/lsUsbTxControl.sv
module lsUsbTxControl
  import lsUsbTxPkg::*;
#(
  parameter int BIT_CLKS  = 10,
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [$clog2(MAX_BYTES+1)-1:0] byteCount,
  input  logic                           hsAck,
  input  logic                           hsNak,
  input  logic                           stuffNow,
  output txStrobes_t                     stb,
  output logic                           fetchReq,
  output logic [BYTE_W-1:0]              hsPid,
  output logic                           busy,
  output logic                           done
);
  localparam int CNT_W = $clog2(MAX_BYTES+1);
  localparam int BC_W  = $clog2(BIT_CLKS);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  txState_t state;
  logic [BC_W-1:0]  bitCnt;
  logic [2:0]       bitIdx;
  logic [CNT_W-1:0] bytesLeft;
  logic             isHs, isNak, lastSent;

  logic wrap, hsAny, countOk, go, consume, finish;

  assign wrap    = (state != ST_IDLE) && (bitCnt == BC_W'(BIT_CLKS-1));
  assign hsAny   = hsAck | hsNak;
  assign countOk = (byteCount >= CNT_W'(MIN_BYTES)) && (byteCount <= CNT_W'(MAX_BYTES));
  assign go      = (state == ST_IDLE) && (hsAny || (start && countOk));
  assign consume = !stuffNow && (bitIdx == 3'd7) && (bytesLeft != '0);
  assign finish  = (state == ST_SEND) && wrap && lastSent && !stuffNow;
  assign hsPid   = isNak ? PID_NAK : PID_ACK;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: stb.loadSync = go;
      ST_ARM:  stb.oeOn     = wrap;
      ST_LEAD: stb.emit     = wrap;
      ST_SEND: begin
        stb.emit     = wrap && !finish;
        stb.driveSe0 = finish;
        stb.commit   = finish && !isHs;
      end
      ST_EOP:  stb.driveJ   = wrap && bitIdx[0];
      ST_TAIL: stb.oeOff    = wrap;
      default: stb = '0;
    endcase
    if (stb.emit && consume) begin
      stb.loadNext = 1'b1;
      stb.useFetch = !isHs;
    end
    fetchReq = stb.loadNext && !isHs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      bitIdx    <= '0;
      bytesLeft <= '0;
      isHs      <= 1'b0;
      isNak     <= 1'b0;
      lastSent  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      bitCnt <= (state == ST_IDLE || wrap) ? '0 : bitCnt + BC_W'(1);
      unique case (state)
        ST_IDLE: if (go) begin
          isHs      <= hsAny;
          isNak     <= !hsAck && hsNak;
          bytesLeft <= hsAny ? ONE_C : byteCount - ONE_C;
          bitIdx    <= '0;
          lastSent  <= 1'b0;
          state     <= ST_ARM;
        end
        ST_ARM:  if (wrap) state <= ST_LEAD;
        ST_LEAD: if (wrap) begin
          bitIdx <= 3'd1;
          state  <= ST_SEND;
        end
        ST_SEND: if (finish) begin
          bitIdx <= '0;
          state  <= ST_EOP;
        end else if (wrap && !stuffNow) begin
          bitIdx <= bitIdx + 3'd1;
          if (bitIdx == 3'd7) begin
            if (bytesLeft != '0) bytesLeft <= bytesLeft - ONE_C;
            else                 lastSent  <= 1'b1;
          end
        end
        ST_EOP: if (wrap) begin
          if (bitIdx[0]) state <= ST_TAIL;
          else           bitIdx <= 3'd1;
        end
        ST_TAIL: if (wrap) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsUsbTxDatapath.sv
module lsUsbTxDatapath
  import lsUsbTxPkg::*;
#(
  parameter int RUN_LIMIT = 6,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobes_t        stb,
  input  logic [BYTE_W-1:0] fetchData,
  input  logic [BYTE_W-1:0] hsPid,
  input  logic [ADDR_W-1:0] newAddr,
  output logic              stuffNow,
  output logic              dPlus,
  output logic              dMinus,
  output logic              lineOe,
  output logic [ADDR_W-1:0] devAddr
);
  localparam int RL_W = $clog2(RUN_LIMIT+1);

  logic [BYTE_W-1:0] shreg;
  logic [RL_W-1:0]   runLen;
  logic              lineK, se0;

  assign stuffNow = (runLen == RL_W'(RUN_LIMIT));
  assign dPlus    = !se0 && lineK;
  assign dMinus   = !se0 && !lineK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      runLen  <= '0;
      lineK   <= 1'b0;
      se0     <= 1'b0;
      lineOe  <= 1'b0;
      devAddr <= '0;
    end else begin
      if (stb.loadSync) begin
        shreg  <= SYNC_BYTE;
        runLen <= '0;
        lineK  <= 1'b0;
        se0    <= 1'b0;
      end
      if (stb.emit) begin
        if (stuffNow) begin
          lineK  <= !lineK;
          runLen <= '0;
        end else begin
          if (!shreg[0]) begin
            lineK  <= !lineK;
            runLen <= '0;
          end else begin
            runLen <= runLen + RL_W'(1);
          end
          shreg <= stb.loadNext ? (stb.useFetch ? fetchData : hsPid)
                                : {1'b0, shreg[BYTE_W-1:1]};
        end
      end
      if (stb.driveSe0) se0 <= 1'b1;
      if (stb.driveJ) begin
        se0   <= 1'b0;
        lineK <= 1'b0;
      end
      if (stb.oeOn)   lineOe  <= 1'b1;
      if (stb.oeOff)  lineOe  <= 1'b0;
      if (stb.commit) devAddr <= newAddr;
    end
  end
endmodule

// File: rtl/lsUsbTx.sv
module lsUsbTx
  import lsUsbTxPkg::*;
#(
  parameter int BIT_CLKS  = 10,
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12,
  parameter int RUN_LIMIT = 6,
  parameter int ADDR_W    = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [$clog2(MAX_BYTES+1)-1:0] byteCount,
  output logic                           fetchReq,
  input  logic [7:0]                     fetchData,
  input  logic                           hsAck,
  input  logic                           hsNak,
  input  logic [ADDR_W-1:0]              newAddr,
  output logic [ADDR_W-1:0]              devAddr,
  output logic                           dPlus,
  output logic                           dMinus,
  output logic                           lineOe,
  output logic                           busy,
  output logic                           done
);
  txStrobes_t        stb;
  logic              stuffNow;
  logic [BYTE_W-1:0] hsPid;

  lsUsbTxControl #(.BIT_CLKS(BIT_CLKS), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byteCount(byteCount),
    .hsAck(hsAck), .hsNak(hsNak), .stuffNow(stuffNow), .stb(stb),
    .fetchReq(fetchReq), .hsPid(hsPid), .busy(busy), .done(done)
  );

  lsUsbTxDatapath #(.RUN_LIMIT(RUN_LIMIT), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .fetchData(fetchData), .hsPid(hsPid),
    .newAddr(newAddr), .stuffNow(stuffNow), .dPlus(dPlus), .dMinus(dMinus),
    .lineOe(lineOe), .devAddr(devAddr)
  );
endmodule

// File: rtl/lsUsbTxChecker.sv
module lsUsbTxChecker #(
  parameter int BIT_CLKS = 10,
  parameter int ADDR_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] devAddr,
  input logic              dPlus,
  input logic              dMinus,
  input logic              lineOe,
  input logic              busy,
  input logic              done
);
  logic [7:0] holdCnt;
  logic [1:0] prevLines;
  logic       lineChg;

  assign lineChg = ({dPlus, dMinus} != prevLines);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdCnt   <= 8'hFF;
      prevLines <= 2'b01;
    end else begin
      prevLines <= {dPlus, dMinus};
      if (lineChg)                holdCnt <= 8'd0;
      else if (holdCnt != 8'hFF)  holdCnt <= holdCnt + 8'd1;
    end
  end

  // R5
  lines_not_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lineOe |-> !(dPlus && dMinus));
  // R9
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  fetch_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq |-> (busy && lineOe));
  // R11
  addr_on_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(devAddr) |-> (lineOe && !dPlus && !dMinus));
  // R7
  hold_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lineOe && $past(lineOe) && lineChg) |-> (holdCnt >= 8'(BIT_CLKS-1)));
  // R8
  release_from_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lineOe) |-> (!$past(dPlus) && $past(dMinus)));
endmodule

bind lsUsbTx lsUsbTxChecker #(.BIT_CLKS(BIT_CLKS), .ADDR_W(ADDR_W)) i_lsUsbTxChecker (
  .clk(clk), .rst_n(rst_n), .fetchReq(fetchReq), .devAddr(devAddr), .dPlus(dPlus),
  .dMinus(dMinus), .lineOe(lineOe), .busy(busy), .done(done)
);

// File: tb/test_lsUsbTx.sv
module test_lsUsbTx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] byteCount = 4'd0;
  logic       fetchReq;
  logic [7:0] fetchData;
  logic       hsAck = 1'b0;
  logic       hsNak = 1'b0;
  logic [6:0] newAddr = 7'd0;
  logic [6:0] devAddr;
  logic       dPlus, dMinus, lineOe, busy, done;

  lsUsbTx i_lsUsbTx (
    .clk(clk), .rst_n(rst_n), .start(start), .byteCount(byteCount), .fetchReq(fetchReq),
    .fetchData(fetchData), .hsAck(hsAck), .hsNak(hsNak), .newAddr(newAddr), .devAddr(devAddr),
    .dPlus(dPlus), .dMinus(dMinus), .lineOe(lineOe), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int vecCnt = 0;
  int missCnt = 0;
  int srcIdx = 0;
  int doneCnt = 0;
  logic [7:0] srcMem [0:15];
  logic [7:0] pkt [0:11];
  logic [3:0] expSym [0:135];
  logic [3:0] symA [0:135];
  logic [3:0] symB [0:135];
  int nSym;
  logic [6:0] expAddr = 7'd0;

  assign fetchData = srcMem[srcIdx[3:0]];
  always @(posedge clk) if (fetchReq) srcIdx <= srcIdx + 1;
  always @(negedge clk) if (done) doneCnt <= doneCnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      missCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushSym(input logic [3:0] s);
    expSym[nSym] = s;
    nSym = nSym + 1;
  endtask

  // expected symbols: {busy, lineOe, dPlus, dMinus}
  task automatic buildExpected(input int nBytes);
    int run;
    logic k;
    run = 0; k = 1'b0; nSym = 0;
    pushSym(4'b1001);
    pushSym(4'b1101);
    for (int b = 0; b < nBytes; b++) begin
      for (int i = 0; i < 8; i++) begin
        if (!pkt[b][i]) begin k = ~k; run = 0; end
        else run = run + 1;
        pushSym({2'b11, k, ~k});
        if (run == 6) begin
          k = ~k; run = 0;
          pushSym({2'b11, k, ~k});
        end
      end
    end
    pushSym(4'b1100);
    pushSym(4'b1100);
    pushSym(4'b1101);
    pushSym(4'b0001);
  endtask

  // kind: 0 data, 1 ack, 2 nak, 3 ack+nak, 4 ack+start
  task automatic runPacket(input int kind, input int cnt, input string bitTag);
    int base, doneBase, nBytes;
    string tag;
    base = srcIdx;
    doneBase = doneCnt;
    pkt[0] = 8'h80;
    nBytes = (kind == 0) ? cnt : 2;
    if (kind != 0) pkt[1] = (kind == 2) ? 8'h5A : 8'hD2;
    else for (int i = 1; i < cnt; i++) srcMem[(base + i - 1) % 16] = pkt[i];
    buildExpected(nBytes);
    @(negedge clk);
    newAddr = 7'($urandom);
    if (kind == 0) expAddr = newAddr;
    byteCount = 4'(cnt);
    start = (kind == 0 || kind == 4);
    hsAck = (kind == 1 || kind == 3 || kind == 4);
    hsNak = (kind == 2 || kind == 3);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; hsAck = 1'b0; hsNak = 1'b0;
    for (int s = 0; s < nSym; s++) begin
      repeat ((s == 0) ? 1 : 2) @(posedge clk);
      @(negedge clk);
      symA[s] = {busy, lineOe, dPlus, dMinus};
      if (s == 5) begin start = 1'b1; byteCount = 4'd3; hsNak = 1'b1; end
      repeat (8) @(posedge clk);
      @(negedge clk);
      symB[s] = {busy, lineOe, dPlus, dMinus};
      if (s == 5) begin start = 1'b0; hsNak = 1'b0; end
    end
    for (int s = 0; s < nSym; s++) begin
      if (s < 2) tag = "R3";
      else if (s < nSym - 4) tag = bitTag;
      else if (s < nSym - 1) tag = "R8";
      else tag = "R9";
      check(symA[s] == expSym[s], tag, symA[s], expSym[s]);
      check(symB[s] == expSym[s], "R7", symB[s], expSym[s]);
    end
    check((srcIdx - base) == ((kind == 0) ? cnt - 1 : 0), (kind == 0) ? "R4" : "R10",
          srcIdx - base, (kind == 0) ? cnt - 1 : 0);
    check((doneCnt - doneBase) == 1, "R9", doneCnt - doneBase, 1);
    check(devAddr == expAddr, "R11", devAddr, expAddr);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !lineOe, "R2", {busy, lineOe}, 0);
  endtask

  task automatic tryBadCount(input int cnt);
    int base;
    base = srcIdx;
    @(negedge clk);
    byteCount = 4'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !lineOe && (srcIdx == base), "R2", {busy, lineOe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    missCnt++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    int kind, cnt;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) srcMem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, lineOe, dPlus, dMinus} == 4'b0001, "R1", {busy, lineOe, dPlus, dMinus}, 1);
    check(!done && !fetchReq && devAddr == 7'd0, "R1", {done, fetchReq, devAddr}, 0);

    // R2 out-of-range counts ignored
    tryBadCount(1);
    tryBadCount(13);
    tryBadCount(0);

    // R4 minimum packet
    pkt[1] = 8'h00;
    runPacket(0, 2, "R5");
    // R6 run of ones across byte boundaries, maximum length
    for (int i = 1; i < 12; i++) pkt[i] = 8'hFF;
    runPacket(0, 12, "R6");
    // R6 trailing stuffed bit before end of packet
    pkt[1] = 8'h55; pkt[2] = 8'hFC;
    runPacket(0, 3, "R6");
    // R10 handshakes and priority
    runPacket(1, 2, "R10");
    runPacket(2, 2, "R10");
    runPacket(3, 2, "R10");
    runPacket(4, 2, "R10");

    for (int n = 0; n < 18; n++) begin
      kind = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0;
      cnt = int'($urandom_range(2, 12));
      for (int i = 1; i < 12; i++) pkt[i] = 8'($urandom);
      runPacket(kind, cnt, "R5");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end
endmodule